// File: doc/BRIEF.md
# Saturating vector integer add/subtract with sticky status

The block adds or subtracts two 128-bit vectors lane by lane. The lanes are 8, 16 or 32 bits wide and signed or unsigned, picked per operation. A lane whose true result falls outside its range is clamped to the nearest limit. Any clamped lane in an operation sets a sticky saturation flag, and the flag stays set until software writes the status register. The status register also holds a non-Java mode bit. It is presented as a 128-bit vector, so it can be moved to and from a vector register without reformatting.

An operation is presented with `op_valid_i` for one cycle. The clamped vector and the flag update are registered on that clock edge. A status write uses the same edge, and when both happen in one cycle the write decides the flag.

Top module: `vsat_addsub`

## Requirements
- R1: `lane_sz_i` selects the lane width: 0 gives sixteen 8-bit lanes, 1 gives eight 16-bit lanes, 2 and 3 both give four 32-bit lanes. Lane n occupies bits [n*W+W-1 : n*W]. Lanes are independent: no carry or borrow crosses a lane boundary.
- R2: With `signed_i`=1, a lane whose true two's-complement sum or difference exceeds the lane maximum gives 0111..1, and one below the lane minimum gives 1000..0.
- R3: With `signed_i`=0 and `sub_i`=0, a lane whose true sum exceeds 2^W-1 gives all ones.
- R4: With `signed_i`=0 and `sub_i`=1, a lane whose true difference is negative gives zero.
- R5: A lane that does not go out of range gives the wrapping (modular) sum or difference.
- R6: `result_o` and `result_valid_o` are registered. The result of an operation accepted on edge k appears after edge k with `result_valid_o`=1. In a cycle without `op_valid_i`, `result_valid_o` goes to 0 after the edge and `result_o` holds its value.
- R7: An accepted operation in which at least one lane was clamped sets the saturation flag after that edge.
- R8: The saturation flag is sticky. Operations with no clamped lane leave it unchanged.
- R9: `stat_o` carries the saturation flag at bit 0 and the non-Java bit at bit 16. Every other bit is zero.
- R10: A write with `stat_wr_i`=1 loads the saturation flag from `stat_wdata_i[0]` and the non-Java bit from `stat_wdata_i[16]`. The new values show on `stat_o` after the edge.
- R11: After reset, the saturation flag is 0, the non-Java bit is 1, `result_o` is zero and `result_valid_o` is 0.
- R12: When a status write and an operation fall in the same cycle, the flag takes the written value, whatever the lanes did. The operation's result is still registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation present this cycle |
| op_a_i | input | 128 | First operand |
| op_b_i | input | 128 | Second operand (subtrahend when subtracting) |
| lane_sz_i | input | 2 | Lane width select (R1) |
| signed_i | input | 1 | 1 = signed lanes, 0 = unsigned |
| sub_i | input | 1 | 1 = a minus b, 0 = a plus b |
| stat_wr_i | input | 1 | Status register write |
| stat_wdata_i | input | 128 | Status write data |
| result_o | output | 128 | Clamped result vector |
| result_valid_o | output | 1 | Result registered from an operation on the last edge |
| stat_o | output | 128 | Status register read view |

## Verification
Two cases are hard to reach by chance. The first is an operation with no clamped lane while the flag is already set. Random byte lanes almost always clamp somewhere, so directed in-range operations are placed right after a saturating one. The second is a status write in the same cycle as a saturating operation. Directed cases cover it in both directions, clearing the flag against a clamping operation and setting it against a clean one. The random run also rewrites the status register at fixed intervals, so the flag is often low when an operation arrives.

// File: rtl/vsat_pkg.sv
package vsat_pkg;
  typedef enum logic [1:0] {
    LSZ_B   = 2'd0,
    LSZ_H   = 2'd1,
    LSZ_W   = 2'd2,
    LSZ_W_A = 2'd3
  } lane_sz_e;

  localparam int unsigned NUM_VARIANTS = 3;

  function automatic int unsigned variant_idx(lane_sz_e sz);
    case (sz)
      LSZ_B:   return 0;
      LSZ_H:   return 1;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/vsat_lane.sv
module vsat_lane #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         signed_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         sat_o
);
  localparam int unsigned XW = W + 2;

  logic [XW-1:0] ax, bx, sum;
  logic          hi, lo;
  logic [W-1:0]  max_v, min_v;

  always_comb begin
    ax  = {{2{signed_i & a_i[W-1]}}, a_i};
    bx  = {{2{signed_i & b_i[W-1]}}, b_i};
    sum = sub_i ? (ax - bx) : (ax + bx);
    if (signed_i) begin
      // signed true value fits W+1 bits; check the two top bits of the lane
      hi    = ~sum[W] &  sum[W-1];
      lo    =  sum[W] & ~sum[W-1];
      max_v = {1'b0, {(W-1){1'b1}}};
      min_v = {1'b1, {(W-1){1'b0}}};
    end else begin
      hi    = ~sum[XW-1] & sum[W];
      lo    =  sum[XW-1];
      max_v = '1;
      min_v = '0;
    end
    res_o = hi ? max_v : (lo ? min_v : sum[W-1:0]);
    sat_o = hi | lo;
  end
endmodule

// File: rtl/vsat_lane_array.sv
module vsat_lane_array #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              signed_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              sat_o
);
  localparam int unsigned NUM_LANES = DATA_W / LANE_W;

  logic [NUM_LANES-1:0] lane_sat;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    vsat_lane #(.W(LANE_W)) u_lane (
      .a_i      (a_i[i*LANE_W +: LANE_W]),
      .b_i      (b_i[i*LANE_W +: LANE_W]),
      .signed_i (signed_i),
      .sub_i    (sub_i),
      .res_o    (res_o[i*LANE_W +: LANE_W]),
      .sat_o    (lane_sat[i])
    );
  end

  assign sat_o = |lane_sat;
endmodule

// File: rtl/vsat_status.sv
module vsat_status #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned SAT_BIT = 0,
  parameter int unsigned NJ_BIT  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_fire_i,
  input  logic              op_sat_i,
  input  logic              wr_i,
  input  logic              wr_sat_i,
  input  logic              wr_nj_i,
  output logic [DATA_W-1:0] stat_o
);
  logic sat_q, nj_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sat_q <= 1'b0;
      nj_q  <= 1'b1;
    end else if (wr_i) begin
      sat_q <= wr_sat_i;
      nj_q  <= wr_nj_i;
    end else if (op_fire_i && op_sat_i) begin
      sat_q <= 1'b1;
    end
  end

  always_comb begin
    stat_o          = '0;
    stat_o[SAT_BIT] = sat_q;
    stat_o[NJ_BIT]  = nj_q;
  end
endmodule

// File: rtl/vsat_addsub.sv
module vsat_addsub #(
  parameter int unsigned DATA_W  = 128,
  parameter int unsigned SAT_BIT = 0,
  parameter int unsigned NJ_BIT  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [1:0]        lane_sz_i,
  input  logic              signed_i,
  input  logic              sub_i,
  input  logic              stat_wr_i,
  input  logic [DATA_W-1:0] stat_wdata_i,
  output logic [DATA_W-1:0] result_o,
  output logic              result_valid_o,
  output logic [DATA_W-1:0] stat_o
);
  import vsat_pkg::*;

  logic [DATA_W-1:0] var_res [NUM_VARIANTS];
  logic              var_sat [NUM_VARIANTS];
  logic [DATA_W-1:0] sel_res;
  logic              sel_sat;
  logic [DATA_W-1:0] result_q;
  logic              valid_q;

  for (genvar k = 0; k < NUM_VARIANTS; k++) begin : g_width
    vsat_lane_array #(
      .DATA_W (DATA_W),
      .LANE_W (8 << k)
    ) u_arr (
      .a_i      (op_a_i),
      .b_i      (op_b_i),
      .signed_i (signed_i),
      .sub_i    (sub_i),
      .res_o    (var_res[k]),
      .sat_o    (var_sat[k])
    );
  end

  always_comb begin
    sel_res = var_res[variant_idx(lane_sz_e'(lane_sz_i))];
    sel_sat = var_sat[variant_idx(lane_sz_e'(lane_sz_i))];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= op_valid_i;
      if (op_valid_i) result_q <= sel_res;
    end
  end

  vsat_status #(
    .DATA_W  (DATA_W),
    .SAT_BIT (SAT_BIT),
    .NJ_BIT  (NJ_BIT)
  ) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_fire_i (op_valid_i),
    .op_sat_i  (sel_sat),
    .wr_i      (stat_wr_i),
    .wr_sat_i  (stat_wdata_i[SAT_BIT]),
    .wr_nj_i   (stat_wdata_i[NJ_BIT]),
    .stat_o    (stat_o)
  );

  assign result_o       = result_q;
  assign result_valid_o = valid_q;
endmodule

// File: rtl/vsat_addsub_chk.sv
module vsat_addsub_chk #(
  parameter int unsigned DATA_W  = 128,
  parameter int unsigned SAT_BIT = 0,
  parameter int unsigned NJ_BIT  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic              stat_wr_i,
  input logic [DATA_W-1:0] stat_wdata_i,
  input logic [DATA_W-1:0] result_o,
  input logic              result_valid_o,
  input logic [DATA_W-1:0] stat_o
);
  localparam logic [DATA_W-1:0] STAT_MASK = (DATA_W'(1) << SAT_BIT) | (DATA_W'(1) << NJ_BIT);

  assert_valid_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |=> result_valid_o);

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> (!result_valid_o && $stable(result_o)));

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[SAT_BIT] && !stat_wr_i) |=> stat_o[SAT_BIT]);

  assert_rise_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[SAT_BIT]) |-> ($past(op_valid_i) || $past(stat_wr_i)));

  assert_reserved_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o & ~STAT_MASK) == '0);

  assert_write_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr_i |=> (stat_o == ($past(stat_wdata_i) & STAT_MASK)));

  assert_nj_only_by_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_wr_i |=> $stable(stat_o[NJ_BIT]));
endmodule

bind vsat_addsub vsat_addsub_chk #(
  .DATA_W  (DATA_W),
  .SAT_BIT (SAT_BIT),
  .NJ_BIT  (NJ_BIT)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .op_valid_i     (op_valid_i),
  .stat_wr_i      (stat_wr_i),
  .stat_wdata_i   (stat_wdata_i),
  .result_o       (result_o),
  .result_valid_o (result_valid_o),
  .stat_o         (stat_o)
);

// File: tb/tb_vsat_addsub.sv
`timescale 1ns/1ps
module tb_vsat_addsub;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic [127:0] op_a = '0, op_b = '0;
  logic [1:0]   lane_sz = '0;
  logic         sgn = 1'b0, sub = 1'b0;
  logic         stat_wr = 1'b0;
  logic [127:0] stat_wdata = '0;
  logic [127:0] result;
  logic         result_valid;
  logic [127:0] stat;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic sat_m = 1'b0;
  logic nj_m  = 1'b1;
  logic [127:0] last_res = '0;

  always #2 clk = ~clk;

  vsat_addsub dut (
    .clk_i (clk), .rst_ni (rst_n), .op_valid_i (op_valid),
    .op_a_i (op_a), .op_b_i (op_b), .lane_sz_i (lane_sz),
    .signed_i (sgn), .sub_i (sub), .stat_wr_i (stat_wr),
    .stat_wdata_i (stat_wdata), .result_o (result),
    .result_valid_o (result_valid), .stat_o (stat)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog expired: actual cycle %0d expected < 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // returns {sat, result}
  function automatic logic [128:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [1:0] sz, input logic sg, input logic sb);
    int w;
    logic [127:0] r;
    logic s;
    longint one, mask, la, lb, t, mx, mn;
    logic [127:0] ta, tb;
    one = 1;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    mask = (one << w) - 1;
    r = '0;
    s = 1'b0;
    for (int i = 0; i < 128 / w; i++) begin
      ta = a >> (i * w);
      tb = b >> (i * w);
      la = longint'({32'd0, ta[31:0]}) & mask;
      lb = longint'({32'd0, tb[31:0]}) & mask;
      if (sg) begin
        if (la >= (one << (w - 1))) la = la - (one << w);
        if (lb >= (one << (w - 1))) lb = lb - (one << w);
        mx = (one << (w - 1)) - 1;
        mn = -(one << (w - 1));
      end else begin
        mx = mask;
        mn = 0;
      end
      t = sb ? la - lb : la + lb;
      if (t > mx) begin t = mx; s = 1'b1; end
      else if (t < mn) begin t = mn; s = 1'b1; end
      r = r | ({64'd0, t & mask} << (i * w));
    end
    return {s, r};
  endfunction

  function automatic logic [127:0] stat_exp();
    logic [127:0] v;
    v = '0;
    v[0] = sat_m;
    v[16] = nj_m;
    return v;
  endfunction

  task automatic run_op(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                        input logic sg, input logic sb, input logic wr, input logic [127:0] wd,
                        input string tag);
    logic [128:0] e;
    @(negedge clk);
    op_valid = 1'b1; op_a = a; op_b = b; lane_sz = sz; sgn = sg; sub = sb;
    stat_wr = wr; stat_wdata = wd;
    e = model(a, b, sz, sg, sb);
    @(posedge clk);
    #1;
    if (wr) begin sat_m = wd[0]; nj_m = wd[16]; end
    else sat_m = sat_m | e[128];
    last_res = e[127:0];
    check(result === e[127:0], tag, result, e[127:0]);
    check(result_valid === 1'b1, "R6 valid", {127'd0, result_valid}, 128'd1);
    check(stat === stat_exp(), wr ? "R12 flag" : "R7 R8 flag", stat, stat_exp());
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    op_valid = 1'b0; stat_wr = 1'b0;
    op_a = {4{$urandom}}; op_b = {4{$urandom}};
    @(posedge clk);
    #1;
    check(result_valid === 1'b0, "R6 idle valid", {127'd0, result_valid}, 128'd0);
    check(result === last_res, "R6 idle hold", result, last_res);
    check(stat === stat_exp(), "R8 idle flag", stat, stat_exp());
  endtask

  task automatic stat_write(input logic [127:0] wd);
    @(negedge clk);
    op_valid = 1'b0; stat_wr = 1'b1; stat_wdata = wd;
    @(posedge clk);
    #1;
    sat_m = wd[0]; nj_m = wd[16];
    check(stat === stat_exp(), "R10 R9 write", stat, stat_exp());
    @(negedge clk);
    stat_wr = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5a17));
    #9;
    check(result === '0 && result_valid === 1'b0, "R11 reset result", result, '0);
    check(stat === 128'h1_0000, "R11 reset status", stat, 128'h1_0000);
    @(negedge clk);
    rst_n = 1'b1;
    idle_cycle();

    // R5: in-range ops keep flag clear
    run_op({16{8'h11}}, {16{8'h22}}, 2'd0, 1'b0, 1'b0, 1'b0, '0, "R5 u8 add");
    run_op({8{16'h1234}}, {8{16'h0234}}, 2'd1, 1'b1, 1'b1, 1'b0, '0, "R5 s16 sub");
    check(stat[0] === 1'b0, "R8 no sat stays clear", stat, '0);
    // R2 signed byte positive and negative
    run_op({{15{8'h00}}, 8'h7f}, {{15{8'h00}}, 8'h01}, 2'd0, 1'b1, 1'b0, 1'b0, '0, "R2 s8 pos");
    idle_cycle();
    // R8: sticky through a clean op
    run_op({16{8'h01}}, {16{8'h01}}, 2'd0, 1'b0, 1'b0, 1'b0, '0, "R8 clean op");
    stat_write(128'h0);
    run_op({{15{8'h00}}, 8'h80}, {{15{8'h00}}, 8'h01}, 2'd0, 1'b1, 1'b1, 1'b0, '0, "R2 s8 neg");
    stat_write(128'h1_0000);
    // R3 / R4 unsigned clamps
    run_op({8{16'hfff0}}, {8{16'h0020}}, 2'd1, 1'b0, 1'b0, 1'b0, '0, "R3 u16 add");
    stat_write(128'h0);
    run_op({4{32'h0000_0001}}, {4{32'h0000_0002}}, 2'd2, 1'b0, 1'b1, 1'b0, '0, "R4 u32 sub");
    run_op({4{32'h7fff_ffff}}, {4{32'hffff_ffff}}, 2'd2, 1'b1, 1'b1, 1'b0, '0, "R2 s32 sub");
    // R1: code 3 also 32-bit lanes, no carry between lanes
    stat_write(128'h0);
    run_op({4{32'h0000_ffff}}, {4{32'h0000_0001}}, 2'd3, 1'b0, 1'b0, 1'b0, '0, "R1 sz3 32-bit");
    check(stat[0] === 1'b0, "R1 sz3 no sat", stat, '0);
    run_op({8{16'h00ff}}, {8{16'h0001}}, 2'd1, 1'b0, 1'b0, 1'b0, '0, "R1 16-bit lanes");
    // R12: write wins in both directions
    run_op({16{8'hff}}, {16{8'hff}}, 2'd0, 1'b0, 1'b0, 1'b1, 128'h0, "R12 clear vs sat");
    run_op({16{8'h01}}, {16{8'h01}}, 2'd0, 1'b0, 1'b0, 1'b1, 128'hffff_ffff, "R12 set vs clean");
    // R9: reserved bits ignored on write
    stat_write({128{1'b1}} ^ 128'h1);
    stat_write(128'hdead_beef_0000_0000_0000_0000_0000_0000);
    idle_cycle();

    for (int n = 0; n < 400; n++) begin
      logic [127:0] a, b;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      if (n % 3 == 0) b = b >> (8 + ($urandom % 8)); // small operands
      if (n % 8 == 0) stat_write({$urandom, $urandom, $urandom, $urandom});
      // R1 R2 R3 R4 R5 random
      run_op(a, b, 2'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom % 16 == 0),
             {$urandom, $urandom, $urandom, $urandom}, "R1 R5 random");
      if (n % 5 == 0) idle_cycle();
    end

    idle_cycle();
    summary();
    $finish;
  end
endmodule